// File: doc/BRIEF.md
# Fixed-Latency Wide-Issue Execution Core

This block executes one wide instruction bundle per clock. Each bundle holds six operation lanes, each bound to one class of function unit: two integer lanes, two memory lanes and two floating-point lanes. Every lane has a fixed latency. Its result is committed to a shared 32 x 32-bit register file exactly when that latency has elapsed. The core never stalls and never checks dependencies. The code generator must space dependent bundles by the producer's latency. A consumer issued earlier reads the stale register value, and a consumer issued exactly at the latency receives the new value through forwarding.

The floating-point lanes do integer addition and multiplication but keep the longer floating-point latency. The memory lanes access a small internal word-addressed data memory. Each committed register write is also shown on a per-lane output strobe with its destination and value, so the exact retirement cycle of every operation can be observed from outside.

Top module: `vliw_core`

## Requirements
- R1: Lane index s selects the class: s=0,1 integer, s=2,3 memory, s=4,5 floating-point. Opcodes are 4 bits: ADD=0, SUB=1, AND=2, OR=3, XOR=4, ADDI=5 (integer); LOAD=8, STORE=9 (memory); FADD=12, FMUL=13 (floating-point). An opcode outside its lane's class writes nothing and raises no strobe.
- R2: An integer operation issued in cycle t raises wr_vld_o[s] in cycle t+1 with its destination and the value a+b, a-b, a&b, a|b, a^b or a+imm. Here a and b are the values of source registers rs1 and rs2.
- R3: A LOAD issued in cycle t uses the word address (a+imm) modulo the memory depth and strobes the loaded word in cycle t+3. A STORE writes b to that address at the end of cycle t+3 and raises no strobe.
- R4: FADD returns a+b and FMUL returns the low 32 bits of a*b. Both strobe in cycle t+4.
- R5: No write becomes visible before its latency. The strobe stays low in the cycles before it, and a bundle that reads the destination earlier gets the old value.
- R6: A bundle issued in the same cycle as a producer's strobe receives the producer's value through forwarding.
- R7: All operands of a bundle are read at issue. A lane never sees a result from another lane of the same bundle.
- R8: A lane whose valid bit is low writes nothing and raises no strobe.
- R9: When several lanes commit the same register in one cycle, the highest-numbered lane wins. The same priority applies both in the register file and on the forwarding path.
- R10: A LOAD completing in the same cycle as a STORE to the same address returns the memory content from before the store.
- R11: The active-low asynchronous reset clears all in-flight lanes, the register file and the data memory, and holds every strobe low. Bundles presented during reset are discarded.
- R12: A new bundle is accepted every cycle with no stall. Back-to-back dependent integer bundles therefore strobe in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | 6 | Per-lane valid bit |
| slot_op_i | input | 6x4 | Per-lane opcode |
| slot_rd_i | input | 6x5 | Per-lane destination register |
| slot_rs1_i | input | 6x5 | Per-lane first source register |
| slot_rs2_i | input | 6x5 | Per-lane second source register |
| slot_imm_i | input | 6x32 | Per-lane immediate |
| wr_vld_o | output | 6 | Per-lane retirement strobe |
| wr_rd_o | output | 6x5 | Destination of the retiring write |
| wr_data_o | output | 6x32 | Value of the retiring write |

## Verification
Two pairs of functions can land in the same cycle. The first is a register commit and an operand read of that same register by a newly issued bundle. The bench provokes it by issuing a reader exactly at the producer's latency, and also one cycle earlier. It judges the two results as new value and stale value, and it repeats the test with two lanes of different latency committing the same register together, where the higher lane must win. The second pair is a store and a load to the same word issued in one bundle, so both complete together. The load must return the word that was there before, and a later load must see the stored word.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int NSLOT = 6;
  localparam int NREG  = 32;
  localparam int XLEN  = 32;
  localparam int OPW   = 4;
  localparam int RIDX  = $clog2(NREG);

  localparam logic [OPW-1:0] OP_ADD   = 4'd0;
  localparam logic [OPW-1:0] OP_SUB   = 4'd1;
  localparam logic [OPW-1:0] OP_AND   = 4'd2;
  localparam logic [OPW-1:0] OP_OR    = 4'd3;
  localparam logic [OPW-1:0] OP_XOR   = 4'd4;
  localparam logic [OPW-1:0] OP_ADDI  = 4'd5;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd8;
  localparam logic [OPW-1:0] OP_STORE = 4'd9;
  localparam logic [OPW-1:0] OP_FADD  = 4'd12;
  localparam logic [OPW-1:0] OP_FMUL  = 4'd13;

  typedef enum logic [1:0] {CLS_INT, CLS_MEM, CLS_FP} cls_e;

  // lane order is architectural: two int, two mem, two fp
  function automatic cls_e slot_cls(int s);
    if (s < 2) return CLS_INT;
    if (s < 4) return CLS_MEM;
    return CLS_FP;
  endfunction

  typedef struct packed {
    logic            vld;
    logic            wr;
    logic            ld;
    logic            st;
    logic [RIDX-1:0] rd;
    logic [XLEN-1:0] val;
    logic [XLEN-1:0] addr;
  } stage_t;

  function automatic stage_t decode_op(cls_e cls, logic vld, logic [OPW-1:0] op,
                                       logic [RIDX-1:0] rd, logic [XLEN-1:0] a,
                                       logic [XLEN-1:0] b, logic [XLEN-1:0] imm);
    stage_t s;
    s    = '0;
    s.rd = rd;
    case (cls)
      CLS_INT: begin
        s.wr = 1'b1;
        case (op)
          OP_ADD:  s.val = a + b;
          OP_SUB:  s.val = a - b;
          OP_AND:  s.val = a & b;
          OP_OR:   s.val = a | b;
          OP_XOR:  s.val = a ^ b;
          OP_ADDI: s.val = a + imm;
          default: s.wr  = 1'b0;
        endcase
      end
      CLS_MEM: begin
        s.addr = a + imm;
        s.val  = b;
        case (op)
          OP_LOAD: begin
            s.ld = 1'b1;
            s.wr = 1'b1;
          end
          OP_STORE: s.st = 1'b1;
          default: ;
        endcase
      end
      CLS_FP: begin
        case (op)
          OP_FADD: begin
            s.wr  = 1'b1;
            s.val = a + b;
          end
          OP_FMUL: begin
            s.wr  = 1'b1;
            s.val = a * b;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
    s.vld = vld & (s.wr | s.st);
    return s;
  endfunction
endpackage

// File: rtl/vliw_slot_pipe.sv
module vliw_slot_pipe
  import vliw_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stage_t in_i,
  output stage_t out_o
);
  stage_t q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) q[k] <= '0;
    end else begin
      q[0] <= in_i;
      for (int k = 1; k < LAT; k++) q[k] <= q[k-1];
    end
  end

  assign out_o = q[LAT-1];
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vliw_pkg::*;
#(
  parameter int NWR = NSLOT,
  parameter int NRD = 2 * NSLOT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NWR-1:0]             we_i,
  input  logic [NWR-1:0][RIDX-1:0]   wa_i,
  input  logic [NWR-1:0][XLEN-1:0]   wd_i,
  input  logic [NRD-1:0][RIDX-1:0]   ra_i,
  output logic [NRD-1:0][XLEN-1:0]   rd_o
);
  logic [XLEN-1:0] regs_q [NREG];

  // ascending loop: highest lane lands last and wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (we_i[w]) regs_q[wa_i[w]] <= wd_i[w];
    end
  end

  // forwarding uses the same priority as the write loop
  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rd_o[p] = regs_q[ra_i[p]];
      for (int w = 0; w < NWR; w++)
        if (we_i[w] && wa_i[w] == ra_i[p]) rd_o[p] = wd_i[w];
    end
  end
endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem
  import vliw_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int NPORT = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0][XLEN-1:0] ra_i,
  output logic [NPORT-1:0][XLEN-1:0] rd_o,
  input  logic [NPORT-1:0]          we_i,
  input  logic [NPORT-1:0][XLEN-1:0] wa_i,
  input  logic [NPORT-1:0][XLEN-1:0] wd_i
);
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [XLEN-1:0] mem_q [WORDS];

  function automatic logic [AW-1:0] idx(logic [XLEN-1:0] a);
    return AW'(a % XLEN'(WORDS));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (we_i[p]) mem_q[idx(wa_i[p])] <= wd_i[p];
    end
  end

  // read before write: same-cycle store is not visible
  always_comb begin
    for (int p = 0; p < NPORT; p++) rd_o[p] = mem_q[idx(ra_i[p])];
  end
endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int INT_LAT    = 1,
  parameter int MEM_LAT    = 3,
  parameter int FP_LAT     = 4,
  parameter int DMEM_WORDS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSLOT-1:0]             slot_vld_i,
  input  logic [NSLOT-1:0][OPW-1:0]    slot_op_i,
  input  logic [NSLOT-1:0][RIDX-1:0]   slot_rd_i,
  input  logic [NSLOT-1:0][RIDX-1:0]   slot_rs1_i,
  input  logic [NSLOT-1:0][RIDX-1:0]   slot_rs2_i,
  input  logic [NSLOT-1:0][XLEN-1:0]   slot_imm_i,
  output logic [NSLOT-1:0]             wr_vld_o,
  output logic [NSLOT-1:0][RIDX-1:0]   wr_rd_o,
  output logic [NSLOT-1:0][XLEN-1:0]   wr_data_o
);
  localparam int NRD      = 2 * NSLOT;
  localparam int MEM_BASE = 2;
  localparam int NMEM     = 2;

  logic [NRD-1:0][RIDX-1:0]  rf_ra;
  logic [NRD-1:0][XLEN-1:0]  rf_rd;
  stage_t                    iss [NSLOT];
  stage_t                    ret [NSLOT];
  logic [NMEM-1:0][XLEN-1:0] dm_ra, dm_rd, dm_wa, dm_wd;
  logic [NMEM-1:0]           dm_we;

  vliw_regfile #(.NWR(NSLOT), .NRD(NRD)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_vld_o),
    .wa_i  (wr_rd_o),
    .wd_i  (wr_data_o),
    .ra_i  (rf_ra),
    .rd_o  (rf_rd)
  );

  vliw_dmem #(.WORDS(DMEM_WORDS), .NPORT(NMEM)) u_dmem (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (dm_ra),
    .rd_o  (dm_rd),
    .we_i  (dm_we),
    .wa_i  (dm_wa),
    .wd_i  (dm_wd)
  );

  for (genvar m = 0; m < NMEM; m++) begin : g_mport
    assign dm_ra[m] = ret[MEM_BASE+m].addr;
    assign dm_wa[m] = ret[MEM_BASE+m].addr;
    assign dm_wd[m] = ret[MEM_BASE+m].val;
    assign dm_we[m] = ret[MEM_BASE+m].vld & ret[MEM_BASE+m].st;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam cls_e CLS = slot_cls(s);
    localparam int   LAT = (CLS == CLS_INT) ? INT_LAT :
                           (CLS == CLS_MEM) ? MEM_LAT : FP_LAT;

    assign rf_ra[2*s]   = slot_rs1_i[s];
    assign rf_ra[2*s+1] = slot_rs2_i[s];

    // operands sampled at issue, result carried down the lane
    always_comb iss[s] = decode_op(CLS, slot_vld_i[s], slot_op_i[s], slot_rd_i[s],
                                   rf_rd[2*s], rf_rd[2*s+1], slot_imm_i[s]);

    vliw_slot_pipe #(.LAT(LAT)) u_pipe (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (iss[s]),
      .out_o (ret[s])
    );

    assign wr_vld_o[s] = ret[s].vld & ret[s].wr;
    assign wr_rd_o[s]  = ret[s].rd;

    if (CLS == CLS_MEM) begin : g_ld
      assign wr_data_o[s] = ret[s].ld ? dm_rd[s-MEM_BASE] : ret[s].val;
    end else begin : g_alu
      assign wr_data_o[s] = ret[s].val;
    end
  end
endmodule

// File: rtl/vliw_core_chk.sv
module vliw_core_chk
  import vliw_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [4:0]           iss_vld_i,
  input logic [OPW-1:0]       op0_i,
  input logic [OPW-1:0]       op2_i,
  input logic [OPW-1:0]       op3_i,
  input logic [OPW-1:0]       op4_i,
  input logic [RIDX-1:0]      rd0_i,
  input logic [NSLOT-1:0]     wr_vld_i,
  input logic [RIDX-1:0]      wr_rd0_i
);
  p_int_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i[0] && op0_i <= OP_ADDI) |=> (wr_vld_i[0] && wr_rd0_i == $past(rd0_i)));

  p_class_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i[0] && op0_i > OP_ADDI) |=> !wr_vld_i[0]);

  p_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_vld_i[1] |=> !wr_vld_i[1]);

  p_ld_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i[3] && op3_i == OP_LOAD) |=> ##2 wr_vld_i[3]);

  p_st_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i[2] && op2_i == OP_STORE) |=> ##2 !wr_vld_i[2]);

  p_fp_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i[4] && (op4_i == OP_FADD || op4_i == OP_FMUL)) |=> ##3 wr_vld_i[4]);

  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |-> wr_vld_i == '0);
endmodule

bind vliw_core vliw_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .iss_vld_i(slot_vld_i[4:0]),
  .op0_i    (slot_op_i[0]),
  .op2_i    (slot_op_i[2]),
  .op3_i    (slot_op_i[3]),
  .op4_i    (slot_op_i[4]),
  .rd0_i    (slot_rd_i[0]),
  .wr_vld_i (wr_vld_o),
  .wr_rd0_i (wr_rd_o[0])
);

// File: tb/vliw_core_bench.sv
`timescale 1ns/1ps
module vliw_core_bench;
  import vliw_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [5:0]       vld;
  logic [5:0][3:0]  op;
  logic [5:0][4:0]  rd, rs1, rs2;
  logic [5:0][31:0] imm;
  logic [5:0]       wr_vld_o;
  logic [5:0][4:0]  wr_rd_o;
  logic [5:0][31:0] wr_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vliw_core u_vliw_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .slot_vld_i(vld), .slot_op_i(op), .slot_rd_i(rd),
    .slot_rs1_i(rs1), .slot_rs2_i(rs2), .slot_imm_i(imm),
    .wr_vld_o(wr_vld_o), .wr_rd_o(wr_rd_o), .wr_data_o(wr_data_o)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [3:0]  opc;
    logic [4:0]  d, a, b;
    logic [31:0] im;
    logic        wr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, OP_ADDI,  5'd1,  5'd0,  5'd0, 32'd5,          1'b1, 32'd5},
    '{3'd1, OP_ADDI,  5'd2,  5'd0,  5'd0, 32'd7,          1'b1, 32'd7},
    '{3'd0, OP_ADD,   5'd3,  5'd1,  5'd2, 32'd0,          1'b1, 32'd12},
    '{3'd1, OP_SUB,   5'd4,  5'd2,  5'd1, 32'd0,          1'b1, 32'd2},
    '{3'd0, OP_AND,   5'd5,  5'd1,  5'd2, 32'd0,          1'b1, 32'd5},
    '{3'd1, OP_OR,    5'd6,  5'd1,  5'd2, 32'd0,          1'b1, 32'd7},
    '{3'd0, OP_XOR,   5'd7,  5'd1,  5'd2, 32'd0,          1'b1, 32'd2},
    '{3'd4, OP_FADD,  5'd8,  5'd1,  5'd2, 32'd0,          1'b1, 32'd12},
    '{3'd5, OP_FMUL,  5'd9,  5'd1,  5'd2, 32'd0,          1'b1, 32'd35},
    '{3'd2, OP_STORE, 5'd0,  5'd0,  5'd9, 32'd3,          1'b0, 32'd0},
    '{3'd3, OP_LOAD,  5'd10, 5'd0,  5'd0, 32'd3,          1'b1, 32'd35},
    '{3'd3, OP_LOAD,  5'd17, 5'd4,  5'd0, 32'd1,          1'b1, 32'd35},
    '{3'd2, OP_LOAD,  5'd18, 5'd0,  5'd0, 32'd19,         1'b1, 32'd35},
    '{3'd1, OP_ADDI,  5'd11, 5'd0,  5'd0, 32'hFFFF_FFFF,  1'b1, 32'hFFFF_FFFF},
    '{3'd4, OP_FMUL,  5'd12, 5'd11, 5'd2, 32'd0,          1'b1, 32'hFFFF_FFF9},
    '{3'd5, OP_FADD,  5'd16, 5'd11, 5'd2, 32'd0,          1'b1, 32'd6}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    vld = '0; op = '0; rd = '0; rs1 = '0; rs2 = '0; imm = '0;
  endtask

  task automatic put(int s, logic [3:0] o, logic [4:0] d, logic [4:0] a,
                     logic [4:0] b, logic [31:0] im);
    vld[s] = 1'b1; op[s] = o; rd[s] = d; rs1[s] = a; rs2[s] = b; imm[s] = im;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int lat_of(int s);
    return (s < 2) ? 1 : (s < 4) ? 3 : 4;
  endfunction

  function automatic string req_of(int s);
    return (s < 2) ? "R2" : (s < 4) ? "R3" : "R4";
  endfunction

  task automatic read_reg(logic [4:0] r, output logic [31:0] v);
    put(0, OP_OR, r, r, r, 32'd0);
    tick(); clr();
    v = wr_data_o[0];
  endtask

  task automatic run_all();
    logic [31:0] v;
    clr();
    #1 rst_ni = 1'b0;
    put(0, OP_ADDI, 5'd22, 5'd0, 5'd0, 32'd77);  // presented during reset
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    clr();
    chk("R11 strobes after reset", 32'(wr_vld_o), 32'd0);
    read_reg(5'd22, v); chk("R11 bundle in reset discarded", v, 32'd0);
    read_reg(5'd1, v);  chk("R11 register cleared", v, 32'd0);

    // table walk: each op strobes exactly at its latency
    for (int i = 0; i < NV; i++) begin
      int s = int'(VEC[i].slot);
      int l = lat_of(s);
      put(s, VEC[i].opc, VEC[i].d, VEC[i].a, VEC[i].b, VEC[i].im);
      tick(); clr();
      for (int k = 1; k <= l; k++) begin
        if (k < l) begin
          chk("R5 no early strobe", 32'(wr_vld_o[s]), 32'd0);
          tick();
        end else begin
          chk(req_of(s), 32'(wr_vld_o[s]), 32'(VEC[i].wr));
          if (VEC[i].wr) chk(req_of(s), wr_data_o[s], VEC[i].exp);
        end
      end
    end

    // equals model: stale before latency, forwarded at latency (r1=5, r2=7)
    put(4, OP_FMUL, 5'd1, 5'd1, 5'd2, 32'd0); tick(); clr();
    put(0, OP_OR, 5'd13, 5'd1, 5'd1, 32'd0);  tick(); clr();
    chk("R5 early reader stale", wr_data_o[0], 32'd5);
    tick();
    put(0, OP_OR, 5'd14, 5'd1, 5'd1, 32'd0);  tick(); clr();
    chk("R5 reader one short stale", wr_data_o[0], 32'd5);
    chk("R4 fmul strobe", 32'(wr_vld_o[4]), 32'd1);
    chk("R4 fmul value", wr_data_o[4], 32'd35);
    put(0, OP_OR, 5'd15, 5'd1, 5'd1, 32'd0);  tick(); clr();
    chk("R6 forwarded at latency", wr_data_o[0], 32'd35);

    // back-to-back dependent chain, no stall
    put(0, OP_ADDI, 5'd20, 5'd0, 5'd0, 32'd1); tick(); clr();
    for (int k = 2; k <= 4; k++) begin
      chk("R12 strobe each cycle", 32'(wr_vld_o[0]), 32'd1);
      chk("R12 chain value", wr_data_o[0], 32'(k - 1));
      put(0, OP_ADDI, 5'd20, 5'd20, 5'd0, 32'd1); tick(); clr();
    end
    chk("R12 chain final", wr_data_o[0], 32'd4);

    // intra-bundle: lane 1 must not see lane 0 result
    put(0, OP_ADDI, 5'd23, 5'd0, 5'd0, 32'd100);
    put(1, OP_ADD,  5'd24, 5'd23, 5'd0, 32'd0);
    tick(); clr();
    chk("R7 producer", wr_data_o[0], 32'd100);
    chk("R7 no same-bundle forwarding", wr_data_o[1], 32'd0);

    // collision, same latency
    put(0, OP_ADDI, 5'd25, 5'd0, 5'd0, 32'd1);
    put(1, OP_ADDI, 5'd25, 5'd0, 5'd0, 32'd2);
    tick(); clr();
    put(0, OP_OR, 5'd26, 5'd25, 5'd25, 32'd0); tick(); clr();
    chk("R9 forwarding priority", wr_data_o[0], 32'd2);
    read_reg(5'd25, v); chk("R9 register priority", v, 32'd2);

    // collision across classes: fp lane 4 vs int lane 0 (r1=35, r2=7)
    put(4, OP_FADD, 5'd27, 5'd1, 5'd2, 32'd0); tick(); clr();
    tick(); tick();
    put(0, OP_ADDI, 5'd27, 5'd0, 5'd0, 32'd9); tick(); clr();
    put(0, OP_OR, 5'd28, 5'd27, 5'd27, 32'd0); tick(); clr();
    chk("R9 cross-class forwarding", wr_data_o[0], 32'd42);
    read_reg(5'd27, v); chk("R9 cross-class register", v, 32'd42);

    // load and store completing together on one address
    put(2, OP_STORE, 5'd0, 5'd0, 5'd2, 32'd5); tick(); clr();
    repeat (3) tick();
    put(2, OP_STORE, 5'd0, 5'd0, 5'd1, 32'd5);
    put(3, OP_LOAD, 5'd29, 5'd0, 5'd0, 32'd5);
    tick(); clr(); tick(); tick();
    chk("R10 load strobe", 32'(wr_vld_o[3]), 32'd1);
    chk("R10 load sees old word", wr_data_o[3], 32'd7);
    tick();
    put(3, OP_LOAD, 5'd30, 5'd0, 5'd0, 32'd5); tick(); clr(); tick(); tick();
    chk("R3 later load sees store", wr_data_o[3], 32'd35);

    // invalid lane and wrong-class opcodes
    put(0, OP_ADDI, 5'd31, 5'd0, 5'd0, 32'd55);
    vld[0] = 1'b0;
    tick(); clr();
    chk("R8 valid low no strobe", 32'(wr_vld_o[0]), 32'd0);
    put(0, OP_FADD, 5'd31, 5'd1, 5'd2, 32'd0); tick(); clr();
    chk("R1 fp opcode in int lane", 32'(wr_vld_o[0]), 32'd0);
    put(4, OP_ADD, 5'd31, 5'd1, 5'd2, 32'd0); tick(); clr();
    tick(); tick(); tick();
    chk("R1 int opcode in fp lane", 32'(wr_vld_o[4]), 32'd0);
    read_reg(5'd31, v); chk("R8 R1 register untouched", v, 32'd0);

    // reset with an operation in flight
    put(5, OP_FMUL, 5'd21, 5'd1, 5'd2, 32'd0); tick(); clr();
    tick();
    rst_ni = 1'b0;
    #1 chk("R11 strobes in reset", 32'(wr_vld_o), 32'd0);
    @(posedge clk); #1 rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R11 flushed lane silent", 32'(wr_vld_o), 32'd0);
      tick();
    end
    read_reg(5'd21, v); chk("R11 flushed dest clear", v, 32'd0);
    read_reg(5'd1, v);  chk("R11 register file clear", v, 32'd0);
  endtask

  initial begin
    clr();
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog actual hang expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule